// File: doc/BRIEF.md
# BCH8 NAND Parity Generator

This block computes the 104-bit BCH remainder over each 512-byte sector of NAND data as the data streams past on an 8-bit or 16-bit bus. The code works over GF(2^13) and lets a downstream decoder correct up to 8 bit errors. Syndrome decoding, error location and bit correction are left to software. The engine only accumulates the remainder and stores it.

Software drives the block through a small word-wide register port. It selects the chip-select to follow, the bus width, the number of sectors per run, and the protected and skipped spare lengths. It arms the engine with three enable bits. After the run it reads up to four result words per sector. A formatter port also returns the 13 parity bytes of any stored sector, already XOR-masked with a fixed constant. A control write clears every result and re-arms the run.

Top module: `bch8_parity_engine`

## Requirements
- R1: A sector's remainder is (D(x)·x^104) mod g(x). Data bytes enter in bus order, each byte most significant bit first. g(x) is the product of the minimal polynomials of α^1, α^3, …, α^15 in GF(2^13), where α is a root of x^13+x^4+x^3+x+1.
- R2: Result words sit at address 0x20 + 4·sector + w. Word w=0 holds remainder bits 31:0, w=1 holds bits 63:32, w=2 holds bits 95:64, and w=3 holds bits 103:96 in its low byte with zeros above.
- R3: Formatter byte k (k = 0..12) is remainder bits [103−8k : 96−8k] XOR mask[k]. The mask sequence is EF 51 2E 09 ED 93 9A C2 97 79 E5 24 B5. An index of 13 or more returns 0.
- R4: When config bit 7 is set, each beat carries two bytes, and the low byte data_in[7:0] is taken first. The results match the same byte stream sent over an 8-bit bus.
- R5: Config bits 6:4 hold the sector count minus one. Sector n is latched into slot n. Status bit 0 (done, read at address 0) rises on the beat that completes the last sector, not before. Slots beyond the run keep their value.
- R6: After every sector except the last, size1/2 bytes are skipped and not fed into the remainder. size1 is a nibble count in size word bits 29:22, at address 2.
- R7: After each 512 data bytes, size0/2 more bytes are included in that sector's remainder. size0 is a nibble count in size word bits 19:12.
- R8: Beats whose data_cs differs from config bits 3:1 are ignored.
- R9: The engine accumulates only when config bits 0, 12 and 16 are all set. Otherwise data beats change nothing.
- R10: Writing address 0 with bit 0 set zeroes all results and clears done.
- R11: Once done is set, further data beats leave the results and done unchanged until the next config or clear write.
- R12: After reset every register reads zero. Config (address 1) reads back bits 0..12 and 16. The size word reads back bits 29:22 and 19:12. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 6 | register write address |
| wr_data | input | 32 | register write data |
| rd_addr | input | 6 | register read address |
| rd_data | output | 32 | register read data (combinational) |
| data_valid | input | 1 | NAND data beat present |
| data_cs | input | 3 | chip-select of the beat |
| data_in | input | 16 | beat data, low byte first |
| fmt_sector | input | 3 | sector slot for the formatter |
| fmt_index | input | 4 | parity byte index |
| fmt_byte | output | 8 | masked parity byte |

## Verification
The bench targets the places where the byte stream and the sector boundaries interact. It sends the same data over 8-bit and 16-bit beats, so a design that takes the high byte first gives different remainders. It runs three sectors with protected and skipped spare bytes between them. A counter that is off by one, or that feeds skipped bytes into the remainder, corrupts every slot after the first. It also checks that done stays low until the final beat. It interleaves beats for another chip-select, sends data with one enable bit missing, and keeps sending after done; a design that lets any of these through changes a stored word. Result packing and masking are checked byte by byte, so a reversed word order or a wrong mask constant shows up at once.

// File: rtl/bch8_pkg.sv
package bch8_pkg;
    localparam int GF_M       = 13;
    localparam int GF_T       = 8;
    localparam int PAR_W      = GF_M * GF_T;
    localparam int PAR_BYTES  = PAR_W / 8;
    localparam int SECT_BYTES = 512;
    localparam logic [GF_M:0] FIELD_POLY = 14'h201b;

    typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_PROT, PH_SKIP} phase_t;

    // GF(2^13) multiply, MSB-first shift and reduce
    function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a, input logic [GF_M-1:0] b);
        logic [GF_M-1:0] p;
        logic            c;
        p = '0;
        for (int i = GF_M - 1; i >= 0; i--) begin
            c = p[GF_M-1];
            p = {p[GF_M-2:0], 1'b0};
            if (c) p = p ^ FIELD_POLY[GF_M-1:0];
            if (b[i]) p = p ^ a;
        end
        return p;
    endfunction

    // binary minimal polynomial of alpha^e: product of (x + beta^(2^j))
    function automatic logic [GF_M:0] min_poly(input int e);
        logic [GF_M-1:0] c [0:GF_M];
        logic [GF_M-1:0] beta;
        logic [GF_M:0]   r;
        beta = 13'd1;
        for (int i = 0; i < e; i++) beta = gf_mul(beta, 13'd2);
        for (int k = 0; k <= GF_M; k++) c[k] = '0;
        c[0] = 13'd1;
        for (int j = 0; j < GF_M; j++) begin
            for (int k = GF_M; k >= 1; k--) c[k] = c[k-1] ^ gf_mul(c[k], beta);
            c[0] = gf_mul(c[0], beta);
            beta = gf_mul(beta, beta);
        end
        for (int k = 0; k <= GF_M; k++) r[k] = c[k][0];
        return r;
    endfunction

    function automatic logic [PAR_W:0] gen_poly();
        logic [PAR_W:0] g;
        logic [PAR_W:0] acc;
        logic [GF_M:0]  m;
        g = 1;
        for (int i = 0; i < GF_T; i++) begin
            m   = min_poly(2 * i + 1);
            acc = '0;
            for (int k = 0; k <= GF_M; k++) if (m[k]) acc = acc ^ (g << k);
            g = acc;
        end
        return g;
    endfunction

    localparam logic [PAR_W:0] GEN_POLY = gen_poly();

    // one byte through the division register, MSB first
    function automatic logic [PAR_W-1:0] lfsr_byte(input logic [PAR_W-1:0] r_in, input logic [7:0] d);
        logic [PAR_W-1:0] r;
        logic             fb;
        r = r_in;
        for (int i = 7; i >= 0; i--) begin
            fb = r[PAR_W-1] ^ d[i];
            r  = {r[PAR_W-2:0], 1'b0};
            if (fb) r = r ^ GEN_POLY[PAR_W-1:0];
        end
        return r;
    endfunction

    function automatic logic [7:0] parity_mask(input logic [3:0] k);
        case (k)
            4'd0:  return 8'hEF;
            4'd1:  return 8'h51;
            4'd2:  return 8'h2E;
            4'd3:  return 8'h09;
            4'd4:  return 8'hED;
            4'd5:  return 8'h93;
            4'd6:  return 8'h9A;
            4'd7:  return 8'hC2;
            4'd8:  return 8'h97;
            4'd9:  return 8'h79;
            4'd10: return 8'hE5;
            4'd11: return 8'h24;
            4'd12: return 8'hB5;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/bch8_par_fmt.sv
module bch8_par_fmt
    import bch8_pkg::*;
(
    input  logic [PAR_W-1:0] rem_i,
    input  logic [3:0]       idx_i,
    output logic [7:0]       byte_o
);
    always_comb begin
        int pos;
        pos    = 0;
        byte_o = '0;
        if (int'(idx_i) < PAR_BYTES) begin
            pos    = PAR_W - 8 - 8 * int'(idx_i);
            byte_o = rem_i[pos +: 8] ^ parity_mask(idx_i);
        end
    end
endmodule

// File: rtl/bch8_rd_mux.sv
module bch8_rd_mux
    import bch8_pkg::*;
#(
    parameter int MAX_SECT = 8,
    parameter int ADDR_W   = 6
) (
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [31:0]                      status_i,
    input  logic [31:0]                      cfg_i,
    input  logic [31:0]                      size_i,
    input  logic [MAX_SECT-1:0][PAR_W-1:0]   res_i,
    output logic [31:0]                      data_o
);
    localparam int RES_BASE = 1 << (ADDR_W - 1);
    localparam int EXT_W    = 128;

    always_comb begin
        int               off;
        int               sec;
        int               wrd;
        logic [EXT_W-1:0] ext;
        off    = 0;
        sec    = 0;
        wrd    = 0;
        ext    = '0;
        data_o = '0;
        if (int'(addr_i) >= RES_BASE) begin
            off = int'(addr_i) - RES_BASE;
            sec = off >> 2;
            wrd = off & 3;
            if (sec < MAX_SECT) begin
                ext    = {{(EXT_W-PAR_W){1'b0}}, res_i[sec]};
                data_o = ext[32*wrd +: 32];
            end
        end else begin
            case (int'(addr_i))
                0: data_o = status_i;
                1: data_o = cfg_i;
                2: data_o = size_i;
                default: data_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/bch8_parity_engine.sv
module bch8_parity_engine
    import bch8_pkg::*;
#(
    parameter int MAX_SECT = 8,
    parameter int ADDR_W   = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [31:0]                 wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [31:0]                 rd_data,
    input  logic                        data_valid,
    input  logic [2:0]                  data_cs,
    input  logic [15:0]                 data_in,
    input  logic [$clog2(MAX_SECT)-1:0] fmt_sector,
    input  logic [3:0]                  fmt_index,
    output logic [7:0]                  fmt_byte
);
    localparam int SECT_W = $clog2(MAX_SECT);
    localparam int CNT_W  = $clog2(SECT_BYTES + 1);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(2);

    typedef struct packed {
        logic                          en;
        logic                          bch8;
        logic                          bch_en;
        logic                          wide;
        logic [2:0]                    cs;
        logic [SECT_W-1:0]             nsm1;
        logic [3:0]                    wrap;
        logic [7:0]                    size0;
        logic [7:0]                    size1;
        phase_t                        phase;
        logic [CNT_W-1:0]              cnt;
        logic [SECT_W-1:0]             sect;
        logic                          done;
        logic [PAR_W-1:0]              lfsr;
        logic [MAX_SECT-1:0][PAR_W-1:0] res;
    } state_t;

    state_t q, d;

    logic [31:0] status_w, cfg_w, size_w;

    always_comb begin
        logic [7:0]       bv;
        logic             fin;
        logic             go;
        logic [CNT_W-1:0] prot_b;
        logic [CNT_W-1:0] skip_b;
        d      = q;
        bv     = '0;
        fin    = 1'b0;
        go     = 1'b0;
        prot_b = CNT_W'(q.size0[7:1]);
        skip_b = CNT_W'(q.size1[7:1]);

        if (data_valid && q.phase != PH_IDLE && data_cs == q.cs) begin
            for (int b = 0; b < 2; b++) begin
                if (b == 0 || q.wide) begin
                    bv  = data_in[8*b +: 8];
                    fin = 1'b0;
                    case (d.phase)
                        PH_DATA, PH_PROT: begin
                            d.lfsr = lfsr_byte(d.lfsr, bv);
                            d.cnt  = d.cnt + 1'b1;
                            if (d.phase == PH_DATA && d.cnt == CNT_W'(SECT_BYTES)) begin
                                d.cnt = '0;
                                if (prot_b == '0) fin = 1'b1;
                                else d.phase = PH_PROT;
                            end else if (d.phase == PH_PROT && d.cnt == prot_b) begin
                                fin = 1'b1;
                            end
                            if (fin) begin
                                d.res[d.sect] = d.lfsr;
                                d.lfsr        = '0;
                                d.cnt         = '0;
                                if (d.sect == q.nsm1) begin
                                    d.done  = 1'b1;
                                    d.phase = PH_IDLE;
                                end else begin
                                    d.sect  = d.sect + 1'b1;
                                    d.phase = (skip_b == '0) ? PH_DATA : PH_SKIP;
                                end
                            end
                        end
                        PH_SKIP: begin
                            d.cnt = d.cnt + 1'b1;
                            if (d.cnt == skip_b) begin
                                d.cnt   = '0;
                                d.phase = PH_DATA;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end

        if (wr_en) begin
            case (wr_addr)
                A_CTRL: if (wr_data[0]) begin
                    go      = q.en & q.bch8 & q.bch_en;
                    d.res   = '0;
                    d.done  = 1'b0;
                    d.sect  = '0;
                    d.cnt   = '0;
                    d.lfsr  = '0;
                    d.phase = go ? PH_DATA : PH_IDLE;
                end
                A_CFG: begin
                    go       = wr_data[0] & wr_data[12] & wr_data[16];
                    d.en     = wr_data[0];
                    d.cs     = wr_data[3:1];
                    d.nsm1   = wr_data[4 +: SECT_W];
                    d.wide   = wr_data[7];
                    d.wrap   = wr_data[11:8];
                    d.bch8   = wr_data[12];
                    d.bch_en = wr_data[16];
                    d.done   = 1'b0;
                    d.sect   = '0;
                    d.cnt    = '0;
                    d.lfsr   = '0;
                    d.phase  = go ? PH_DATA : PH_IDLE;
                end
                A_SIZE: begin
                    d.size0 = wr_data[19:12];
                    d.size1 = wr_data[29:22];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        status_w = {31'b0, q.done};
        cfg_w    = {15'b0, q.bch_en, 3'b0, q.bch8, q.wrap, q.wide, q.nsm1, q.cs, q.en};
        size_w   = {2'b0, q.size1, 2'b0, q.size0, 12'b0};
    end

    bch8_rd_mux #(
        .MAX_SECT (MAX_SECT),
        .ADDR_W   (ADDR_W)
    ) rd_mux_i (
        .addr_i   (rd_addr),
        .status_i (status_w),
        .cfg_i    (cfg_w),
        .size_i   (size_w),
        .res_i    (q.res),
        .data_o   (rd_data)
    );

    bch8_par_fmt fmt_i (
        .rem_i  (q.res[fmt_sector]),
        .idx_i  (fmt_index),
        .byte_o (fmt_byte)
    );
endmodule

// File: rtl/bch8_parity_chk.sv
module bch8_parity_chk
    import bch8_pkg::*;
#(
    parameter int MAX_SECT = 8,
    parameter int ADDR_W   = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [31:0]                   wr_data,
    input logic                          data_valid,
    input logic [2:0]                    data_cs,
    input logic [2:0]                    cfg_cs,
    input logic                          idle,
    input logic                          done,
    input logic [$clog2(MAX_SECT)-1:0]   sect,
    input logic [$clog2(MAX_SECT)-1:0]   nsm1,
    input logic [PAR_W-1:0]              lfsr,
    input logic [MAX_SECT*PAR_W-1:0]     res
);
    assert_clear_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0 && wr_data[0]) |=> (res == '0 && !done));

    assert_idle_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !wr_en) |=> ($stable(lfsr) && $stable(res) && $stable(done)));

    assert_cs_filter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && data_valid && data_cs != cfg_cs) |=> ($stable(lfsr) && $stable(res) && $stable(done)));

    assert_done_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_en) |=> (done && $stable(res)));

    assert_sect_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sect <= nsm1);

    assert_done_on_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(data_valid));
endmodule

bind bch8_parity_engine bch8_parity_chk #(
    .MAX_SECT (MAX_SECT),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .data_valid (data_valid),
    .data_cs    (data_cs),
    .cfg_cs     (q.cs),
    .idle       (q.phase == bch8_pkg::PH_IDLE),
    .done       (q.done),
    .sect       (q.sect),
    .nsm1       (q.nsm1),
    .lfsr       (q.lfsr),
    .res        (q.res)
);

// File: tb/bch8_parity_engine_tb_top.sv
module bch8_parity_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        data_valid = 1'b0;
    logic [2:0]  data_cs = '0;
    logic [15:0] data_in = '0;
    logic [2:0]  fmt_sector = '0;
    logic [3:0]  fmt_index = '0;
    logic [7:0]  fmt_byte;

    int tests = 0;
    int fails = 0;

    localparam logic [7:0] TB_MASK [0:12] = '{8'hEF, 8'h51, 8'h2E, 8'h09, 8'hED, 8'h93,
                                              8'h9A, 8'hC2, 8'h97, 8'h79, 8'hE5, 8'h24, 8'hB5};

    logic [104:0] tb_g;
    logic [7:0]   qb [$];

    always #4 clk = ~clk;

    bch8_parity_engine dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .data_valid(data_valid), .data_cs(data_cs),
        .data_in(data_in), .fmt_sector(fmt_sector), .fmt_index(fmt_index), .fmt_byte(fmt_byte)
    );

    // field arithmetic: full product then reduction
    function automatic logic [12:0] tb_mul(input logic [12:0] a, input logic [12:0] b);
        logic [24:0] p;
        p = '0;
        for (int i = 0; i < 13; i++) if (a[i]) p = p ^ (25'(b) << i);
        for (int i = 24; i >= 13; i--) if (p[i]) p = p ^ (25'h201b << (i - 13));
        return p[12:0];
    endfunction

    function automatic logic [13:0] tb_min(input int e);
        logic [12:0] conj [0:12];
        logic [12:0] c [0:13];
        logic [12:0] b;
        logic [13:0] r;
        b = 13'd1;
        for (int i = 0; i < e; i++) b = tb_mul(b, 13'd2);
        for (int j = 0; j < 13; j++) begin conj[j] = b; b = tb_mul(b, b); end
        for (int k = 0; k < 14; k++) c[k] = '0;
        c[0] = 13'd1;
        for (int j = 0; j < 13; j++) begin
            for (int k = 13; k > 0; k--) c[k] = c[k-1] ^ tb_mul(conj[j], c[k]);
            c[0] = tb_mul(conj[j], c[0]);
        end
        for (int k = 0; k < 14; k++) r[k] = c[k][0];
        return r;
    endfunction

    function automatic logic [7:0] pat(input int s, input int k, input int seed);
        logic [31:0] v;
        v = 32'(k * 37 + s * 101 + seed * 11 + (k >> 3) * seed);
        return v[7:0] ^ v[12:5];
    endfunction

    function automatic logic [103:0] tb_rem(input int s, input int nbytes, input int seed);
        logic [103:0] r;
        logic [7:0]   dv;
        logic         fb;
        r = '0;
        for (int k = 0; k < nbytes; k++) begin
            dv = pat(s, k, seed);
            for (int i = 7; i >= 0; i--) begin
                fb = r[103] ^ dv[i];
                r  = r << 1;
                if (fb) r = r ^ tb_g[103:0];
            end
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic send_range(input bit wide, input logic [2:0] cs, input int lo, input int hi);
        int i;
        i = lo;
        while (i < hi) begin
            @(negedge clk);
            data_valid = 1'b1;
            data_cs    = cs;
            data_in    = {(wide && i + 1 < hi) ? qb[i+1] : 8'h00, qb[i]};
            i += wide ? 2 : 1;
        end
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    task automatic check_sector(input int slot, input logic [103:0] er, input string tag);
        logic [31:0]  v;
        logic [127:0] ext;
        ext = {24'b0, er};
        for (int w = 0; w < 4; w++) begin
            rd(6'(32 + slot * 4 + w), v);
            chk($sformatf("%s/R2 slot%0d word%0d", tag, slot, w), v, ext[32*w +: 32]);
        end
        fmt_sector = 3'(slot);
        for (int k = 0; k < 13; k++) begin
            fmt_index = 4'(k);
            #1;
            chk($sformatf("%s/R3 slot%0d byte%0d", tag, slot, k), {24'b0, fmt_byte},
                {24'b0, er[103-8*k -: 8] ^ TB_MASK[k]});
        end
    endtask

    function automatic logic [31:0] cfg_go(input logic [2:0] cs, input logic [2:0] nsm1, input bit wide);
        return 32'h0001_1600 | 32'h1 | (32'(cs) << 1) | (32'(nsm1) << 4) | (32'(wide) << 7);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(6'd0, v);  chk("R12 status after reset", v, 0);
        rd(6'd1, v);  chk("R12 config after reset", v, 0);
        rd(6'd32, v); chk("R12 result after reset", v, 0);
        fmt_sector = 0; fmt_index = 4'd0; #1;
        chk("R3 mask byte0 on zero remainder", {24'b0, fmt_byte}, 32'hEF);
        fmt_index = 4'd13; #1;
        chk("R3 index 13 reads zero", {24'b0, fmt_byte}, 0);
    endtask

    task automatic t_single8();
        logic [31:0] v;
        qb.delete();
        for (int k = 0; k < 512; k++) qb.push_back(pat(0, k, 1));
        wr(6'd2, 32'h0);
        wr(6'd1, cfg_go(3'd0, 3'd0, 1'b0));
        send_range(1'b0, 3'd0, 0, 512);
        check_sector(0, tb_rem(0, 512, 1), "R1 8-bit");
        rd(6'd0, v); chk("R5 done after one sector", v, 1);
    endtask

    task automatic t_wide16();
        wr(6'd0, 32'h1);
        wr(6'd1, cfg_go(3'd0, 3'd0, 1'b1));
        send_range(1'b1, 3'd0, 0, 512);
        check_sector(0, tb_rem(0, 512, 1), "R4 16-bit");
    endtask

    task automatic t_multi();
        logic [31:0] v;
        qb.delete();
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < 514; k++) qb.push_back(pat(s, k, 2));
            if (s < 2) for (int k = 0; k < 16; k++) qb.push_back(8'hA5 ^ 8'(k));
        end
        wr(6'd0, 32'h1);
        wr(6'd2, (32'd32 << 22) | (32'd4 << 12));
        wr(6'd1, cfg_go(3'd2, 3'd2, 1'b0));
        send_range(1'b0, 3'd2, 0, qb.size() - 1);
        rd(6'd0, v); chk("R5 done low before last byte", v, 0);
        send_range(1'b0, 3'd2, qb.size() - 1, qb.size());
        rd(6'd0, v); chk("R5 done after third sector", v, 1);
        for (int s = 0; s < 3; s++) check_sector(s, tb_rem(s, 514, 2), "R6 R7 multi");
        rd(6'd44, v); chk("R5 unused slot3 stays zero", v, 0);
    endtask

    task automatic t_cs();
        qb.delete();
        for (int k = 0; k < 512; k++) qb.push_back(pat(0, k, 3));
        wr(6'd0, 32'h1);
        wr(6'd2, 32'h0);
        wr(6'd1, cfg_go(3'd3, 3'd0, 1'b0));
        for (int k = 0; k < 512; k++) begin
            @(negedge clk);
            data_valid = 1'b1; data_cs = 3'd3; data_in = {8'h00, qb[k]};
            @(negedge clk);
            data_cs = 3'd5; data_in = 16'h005A;
        end
        @(negedge clk);
        data_valid = 1'b0;
        check_sector(0, tb_rem(0, 512, 3), "R8 cs filter");
    endtask

    task automatic t_gate();
        logic [31:0] v;
        wr(6'd0, 32'h1);
        wr(6'd1, 32'h0000_1001);
        send_range(1'b0, 3'd0, 0, 512);
        rd(6'd32, v); chk("R9 no bch enable: word0 zero", v, 0);
        rd(6'd0, v);  chk("R9 no bch enable: done low", v, 0);
        wr(6'd1, 32'h0001_0001);
        send_range(1'b0, 3'd0, 0, 512);
        rd(6'd33, v); chk("R9 no bch8 select: word1 zero", v, 0);
        fmt_sector = 0; fmt_index = 4'd0; #1;
        chk("R9 formatter still mask only", {24'b0, fmt_byte}, 32'hEF);
    endtask

    task automatic t_after_done();
        logic [31:0] v;
        qb.delete();
        for (int k = 0; k < 512; k++) qb.push_back(pat(0, k, 4));
        wr(6'd1, cfg_go(3'd0, 3'd0, 1'b0));
        send_range(1'b0, 3'd0, 0, 512);
        send_range(1'b0, 3'd0, 0, 64);
        check_sector(0, tb_rem(0, 512, 4), "R11 after done");
        rd(6'd0, v); chk("R11 done stays", v, 1);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(6'd0, 32'h1);
        for (int w = 0; w < 4; w++) begin
            rd(6'(32 + w), v); chk($sformatf("R10 word%0d cleared", w), v, 0);
        end
        rd(6'd0, v); chk("R10 done cleared", v, 0);
        fmt_sector = 0; fmt_index = 4'd5; #1;
        chk("R10 formatter mask only", {24'b0, fmt_byte}, 32'h93);
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        wr(6'd1, 32'h0001_1B5F);
        rd(6'd1, v); chk("R12 config readback", v, 32'h0001_1B5F);
        wr(6'd1, 32'hFFFF_FFFF);
        rd(6'd1, v); chk("R12 config reserved bits", v, 32'h0001_1FFF);
        wr(6'd2, 32'hFFFF_FFFF);
        rd(6'd2, v); chk("R12 size reserved bits", v, 32'h3FCF_F000);
    endtask

    initial begin
        logic [13:0] m;
        logic [104:0] acc;
        tb_g = 105'd1;
        for (int i = 1; i <= 15; i += 2) begin
            m   = tb_min(i);
            acc = '0;
            for (int k = 0; k < 14; k++) if (m[k]) acc = acc ^ (tb_g << k);
            tb_g = acc;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single8();
        t_wide16();
        t_multi();
        t_cs();
        t_gate();
        t_after_done();
        t_clear();
        t_cfg();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule